// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block sits in the command and address path of a registered memory module. Each rising clock edge re-registers the command stream toward the memory devices. Every registered signal fans out to two identical output copies, A and B, so that two groups of devices can be driven.

The 22 address, bank and command signals form the gated group. They update only when a chip select is active, which saves switching power when no device is addressed. The chip selects, clock enable and on-die termination signals form the free-running group, which is re-registered on every edge. A mode input turns the gating off, and then both groups update every cycle.

A small state machine records what happened at the last edge:
- `ST_RESET`: held while reset is active.
- `ST_LOAD`: the gated group was captured.
- `ST_HOLD`: gating blocked the capture.

It has two named transitions. The transition `load` (any state to `ST_LOAD`) is taken when capture is allowed. The transition `block` (any state to `ST_HOLD`) is taken otherwise. The decoded `ST_LOAD` state appears as a capture strobe for a downstream checker.

An active-low reset clears every register at once. Its release is synchronised to the clock.

Top module: `csg_cmd_register`

## Requirements
- R1: With `gate_en` high and at least one bit of `cs_n` low (the chip selects are active low), `gq_a`/`gq_b` take the value that `cmd_in` had at the rising edge. The field layout is: `cmd_in[15:0]` address, `[18:16]` bank, `[19]` row strobe, `[20]` column strobe, `[21]` write enable.
- R2: With `gate_en` high and `cs_n` equal to 2'b11, the gated outputs keep their previous value across the edge.
- R3: With `gate_en` low, the gated outputs take `cmd_in` at every edge, whatever `cs_n` is.
- R4: `cs_q_*`, `cke_q_*` and `odt_q_*` take `cs_n`, `cke` and `odt` at every edge in both modes.
- R5: Each A output always equals its B output.
- R6: While `rst_n` is low, every output is 0, and reset assertion takes effect without a clock edge. After `rst_n` rises, the first edge that loads any register is the third rising edge.
- R7: `capt_q` is high during the cycle after an edge at which the gated group was loaded, and low after an edge at which it was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| gate_en | input | 1 | 1 = chip-select gating on, 0 = update every edge |
| cs_n | input | 2 | Active-low chip selects |
| cke | input | 1 | Clock enable input |
| odt | input | 1 | On-die termination input |
| cmd_in | input | 22 | Address, bank and command strobes |
| gq_a | output | 22 | Gated group, copy A |
| gq_b | output | 22 | Gated group, copy B |
| cs_q_a | output | 2 | Registered chip selects, copy A |
| cs_q_b | output | 2 | Registered chip selects, copy B |
| cke_q_a | output | 1 | Registered clock enable, copy A |
| cke_q_b | output | 1 | Registered clock enable, copy B |
| odt_q_a | output | 1 | Registered termination, copy A |
| odt_q_b | output | 1 | Registered termination, copy B |
| capt_q | output | 1 | Gated-group capture strobe |

## Verification
The clocked properties assume that `gate_en`, `cs_n` and `cmd_in` are stable around each rising edge. They also assume the properties are evaluated only once the synchronised reset is released. The stimulus meets this by changing every input on the falling edge. It asserts `rst_n` only between edges and releases it on a falling edge. It then waits out the synchroniser before checking any loading behaviour.

// File: rtl/csg_pkg.sv
package csg_pkg;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 3;
    localparam int STRB_W = 3;
    localparam int CMD_W  = ADDR_W + BANK_W + STRB_W;
    localparam int CS_W   = 2;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2
    } csg_state_e;
endpackage

// File: rtl/csg_rst_sync.sv
module csg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/csg_dup_reg.sv
module csg_dup_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_a <= '0;
        else if (en) q_a <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_b <= '0;
        else if (en) q_b <= d;
    end

    // R5: both copies track each other
    p_copies_match_r5: assert property (@(posedge clk) q_a == q_b);
endmodule

// File: rtl/csg_gate_fsm.sv
module csg_gate_fsm
    import csg_pkg::*;
#(
    parameter int N_CS = CS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_en,
    input  logic [N_CS-1:0] cs_n,
    output logic            load_en,
    output logic            capt_q
);
    csg_state_e state, state_nx;

    always_comb begin
        load_en  = !gate_en || !(&cs_n);
        state_nx = load_en ? ST_LOAD : ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_LOAD:  capt_q = 1'b1;
            ST_HOLD:  capt_q = 1'b0;
            default:  capt_q = 1'b0;
        endcase
    end

    // R7: strobe follows the capture decision one edge later
    p_strobe_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && &cs_n) |=> !capt_q);
    p_strobe_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en) |=> capt_q);
endmodule

// File: rtl/csg_cmd_register.sv
module csg_cmd_register
    import csg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [CS_W-1:0]  cs_n,
    input  logic             cke,
    input  logic             odt,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [CMD_W-1:0] gq_a,
    output logic [CMD_W-1:0] gq_b,
    output logic [CS_W-1:0]  cs_q_a,
    output logic [CS_W-1:0]  cs_q_b,
    output logic             cke_q_a,
    output logic             cke_q_b,
    output logic             odt_q_a,
    output logic             odt_q_b,
    output logic             capt_q
);
    localparam int FREE_W = CS_W + 2;

    logic              rst_sync_n;
    logic              load_en;
    logic [FREE_W-1:0] free_a, free_b;

    csg_rst_sync #(.STAGES(2)) u_rst (
        .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
    );

    csg_gate_fsm #(.N_CS(CS_W)) u_fsm (
        .clk(clk), .rst_n(rst_sync_n), .gate_en(gate_en), .cs_n(cs_n),
        .load_en(load_en), .capt_q(capt_q)
    );

    csg_dup_reg #(.W(CMD_W)) u_gated (
        .clk(clk), .rst_n(rst_sync_n), .en(load_en), .d(cmd_in),
        .q_a(gq_a), .q_b(gq_b)
    );

    csg_dup_reg #(.W(FREE_W)) u_free (
        .clk(clk), .rst_n(rst_sync_n), .en(1'b1), .d({cs_n, cke, odt}),
        .q_a(free_a), .q_b(free_b)
    );

    assign {cs_q_a, cke_q_a, odt_q_a} = free_a;
    assign {cs_q_b, cke_q_b, odt_q_b} = free_b;

    // R1
    p_select_load_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (gate_en && !(&cs_n)) |=> (gq_a == $past(cmd_in)));
    // R2
    p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (gate_en && &cs_n) |=> $stable(gq_a));
    // R3
    p_open_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!gate_en) |=> (gq_b == $past(cmd_in)));
    // R4
    p_free_group_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        1'b1 |=> (cs_q_a == $past(cs_n) && cke_q_b == $past(cke) && odt_q_a == $past(odt)));
    // R6
    p_reset_clear_r6: assert property (@(posedge clk)
        !rst_n |-> (gq_a == '0 && gq_b == '0 && cs_q_b == '0 && !capt_q));
endmodule

// File: tb/sim_csg_cmd_register.sv
module sim_csg_cmd_register;
    localparam int CLK_P = 10;
    localparam int CW = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_en = 1'b1;
    logic [1:0] cs_n = 2'b11;
    logic cke = 1'b0, odt = 1'b0;
    logic [CW-1:0] cmd_in = '0;
    logic [CW-1:0] gq_a, gq_b;
    logic [1:0] cs_q_a, cs_q_b;
    logic cke_q_a, cke_q_b, odt_q_a, odt_q_b, capt_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [CW-1:0] exp_g;

    always #(CLK_P/2) clk = ~clk;

    csg_cmd_register u0 (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n(cs_n), .cke(cke),
        .odt(odt), .cmd_in(cmd_in), .gq_a(gq_a), .gq_b(gq_b), .cs_q_a(cs_q_a),
        .cs_q_b(cs_q_b), .cke_q_a(cke_q_a), .cke_q_b(cke_q_b), .odt_q_a(odt_q_a),
        .odt_q_b(odt_q_b), .capt_q(capt_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_gated(input string tag, input logic cap);
        chk({tag, " gq_a"}, 32'(gq_a), 32'(exp_g));
        chk("R5 gq_b copy", 32'(gq_b), 32'(gq_a));
        chk("R7 capt_q", 32'(capt_q), 32'(cap));
    endtask

    task automatic step(input logic g, input logic [1:0] cs, input logic [CW-1:0] v);
        gate_en = g; cs_n = cs; cmd_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R6 gq_a in reset", 32'(gq_a), 0);
        chk("R6 gq_b in reset", 32'(gq_b), 0);
        chk("R6 cs_q in reset", 32'({cs_q_a, cs_q_b}), 0);
        chk("R6 capt_q in reset", 32'(capt_q), 0);
    endtask

    task automatic t_release();
        rst_n = 1'b1;
        step(1'b0, 2'b00, 22'h15A5A5);
        chk("R6 no load edge1", 32'(gq_a), 0);
        step(1'b0, 2'b00, 22'h15A5A5);
        chk("R6 no load edge2", 32'(gq_a), 0);
        step(1'b0, 2'b00, 22'h15A5A5);
        exp_g = 22'h15A5A5;
        chk_gated("R6 load at edge3", 1'b1);
    endtask

    task automatic t_select();
        step(1'b1, 2'b10, 22'h000001); exp_g = 22'h000001; chk_gated("R1 cs0", 1'b1);
        step(1'b1, 2'b01, 22'h3F0000); exp_g = 22'h3F0000; chk_gated("R1 cs1", 1'b1);
        step(1'b1, 2'b00, 22'h2AAAAA); exp_g = 22'h2AAAAA; chk_gated("R1 both", 1'b1);
    endtask

    task automatic t_hold();
        step(1'b1, 2'b11, 22'h111111); chk_gated("R2 hold a", 1'b0);
        step(1'b1, 2'b11, 22'h3FFFFF); chk_gated("R2 hold b", 1'b0);
        chk("R4 cs_q during hold", 32'(cs_q_a), 32'd3);
    endtask

    task automatic t_open();
        step(1'b0, 2'b11, 22'h0F0F0F); exp_g = 22'h0F0F0F; chk_gated("R3 open idle cs", 1'b1);
        step(1'b0, 2'b11, 22'h30F00F); exp_g = 22'h30F00F; chk_gated("R3 open next", 1'b1);
    endtask

    task automatic t_free();
        for (int i = 0; i < 8; i++) begin
            cke = i[0]; odt = i[1];
            step(1'b1, {i[2], ~i[2]}, 22'(i));
            chk("R4 cs_q_a", 32'(cs_q_a), 32'({i[2], ~i[2]}));
            chk("R4 cke_q_a", 32'(cke_q_a), 32'(i[0]));
            chk("R4 odt_q_a", 32'(odt_q_a), 32'(i[1]));
            chk("R5 free copies", 32'({cs_q_b, cke_q_b, odt_q_b}), 32'({cs_q_a, cke_q_a, odt_q_a}));
        end
        step(1'b1, 2'b11, 22'h0);
        cke = 1'b1; odt = 1'b1;
        step(1'b1, 2'b11, 22'h0);
        chk("R4 cke with no select", 32'(cke_q_b), 1);
        chk("R4 odt with no select", 32'(odt_q_b), 1);
    endtask

    task automatic t_async_reset();
        #(CLK_P/4) rst_n = 1'b0;
        #1;
        t_reset_state();
        @(negedge clk);
        exp_g = '0;
        t_release();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_g = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_release();
        t_select();
        t_hold();
        t_open();
        t_free();
        t_select();
        t_async_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule